// File: doc/BRIEF.md
# Differential Phase Keying Bit Encoder and Decoder

This block holds the digital half of a differential phase-keyed link. The transmit side turns a message bit stream into a line stream in which a message 1 keeps the line level of the previous symbol and a message 0 inverts it. Only the change between two symbols carries information, so a receiver can recover the message without a locked carrier phase. The receive side compares each received line bit with the one received before it and rebuilds the message bit.

The two halves are independent and share only the clock and synchronous reset. A configuration input gives the starting line level. The encoder loads it on reset and presents it once as a reference symbol that carries no message. A decoder fed by the encoder takes that first symbol as its own reference. Both halves add one clock of latency and keep their state while their input valid is low. A parameter selects the inverting comparison, which is the default, or the plain exclusive-or rule. Analog modulation, mixing and filtering are outside this block.

Top module: `dpsk_codec`

## Requirements
- R1: On every clock edge with `rst` high the encoder loads `ref_bit`. In the following cycle `enc_out_valid` is 1, `enc_out_bit` equals `ref_bit` and `dec_out_valid` is 0.
- R2: For each accepted message bit m, the encoded bit is NOT(m XOR p), where p is the previous encoded bit (the reference for the first message bit). A 1 keeps the line level and a 0 inverts it.
- R3: `enc_out_valid` is 1 exactly in the cycle after a cycle with `enc_in_valid` high. `enc_out_bit` keeps its value in cycles after `enc_in_valid` was low.
- R4: The first bit the decoder accepts after reset produces no output (`dec_out_valid` stays 0) and becomes its reference.
- R5: Every later accepted received bit r gives `dec_out_valid` = 1 one cycle later, with `dec_out_bit` = NOT(r XOR q), where q is the previously accepted received bit. `dec_out_valid` is 0 after a cycle with `dec_in_valid` low.
- R6: Cycles with the input valid low change neither side's stored previous bit. Output after a gap uses the last accepted bit from before the gap.
- R7: With the encoder output fed straight into the decoder input from reset onward, the decoder reproduces the message bits in order.
- R8: In that loop, inverting one encoded message symbol makes exactly two consecutive decoded bits wrong: the bit of the corrupted symbol and the one after it.
- R9: `ref_bit` is ignored while `rst` is low. Changing it mid-stream leaves the encoded stream unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ref_bit | input | 1 | Starting line level, taken on reset |
| enc_in_valid | input | 1 | Message bit present |
| enc_in_bit | input | 1 | Message bit |
| enc_out_valid | output | 1 | Encoded symbol present |
| enc_out_bit | output | 1 | Encoded line bit |
| dec_in_valid | input | 1 | Received line bit present |
| dec_in_bit | input | 1 | Received line bit |
| dec_out_valid | output | 1 | Decoded message bit present |
| dec_out_bit | output | 1 | Decoded message bit |

## Verification
A wrong stored line level in the encoder shows on the very next accepted message bit: the encoded symbol comes out inverted and stays inverted for the rest of the stream. A decoder whose stored previous bit is wrong corrupts only its next output, which is the same pairing that a line error produces. A missing or stuck reference flag shows at once as an extra or a missing `dec_out_valid` right after reset. Gaps in the valid strobes are mixed into every stream, so state that drifts during idle cycles shows on the first output after the gap.

// File: rtl/dpsk_pkg.sv
package dpsk_pkg;
   typedef enum logic { RULE_XOR = 1'b0, RULE_XNOR = 1'b1 } rule_e;

   // Message value that leaves the line level unchanged under a rule.
   function automatic logic keep_value(rule_e r);
      return (r == RULE_XNOR);
   endfunction
endpackage

// File: rtl/dpsk_rule.sv
module dpsk_rule
   import dpsk_pkg::*;
#(
   parameter rule_e RULE = RULE_XNOR
) (
   input  logic a,
   input  logic b,
   output logic y
);
   generate
      if (RULE == RULE_XNOR) begin : g_xnor
         assign y = ~(a ^ b);
      end else begin : g_xor
         assign y = a ^ b;
      end
   endgenerate
endmodule

// File: rtl/dpsk_encoder.sv
module dpsk_encoder
   import dpsk_pkg::*;
#(
   parameter rule_e RULE = RULE_XNOR
) (
   input  logic clk,
   input  logic rst,
   input  logic ref_bit,
   input  logic in_valid,
   input  logic in_bit,
   output logic out_valid,
   output logic out_bit
);
   localparam logic KEEP = keep_value(RULE);

   logic level_q;
   logic vld_q;
   logic level_d;

   dpsk_rule #(.RULE(RULE)) u_rule (
      .a (in_bit),
      .b (level_q),
      .y (level_d)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         level_q <= ref_bit;
         vld_q   <= 1'b1;
      end else begin
         vld_q <= in_valid;
         if (in_valid) level_q <= level_d;
      end
   end

   assign out_valid = vld_q;
   assign out_bit   = level_q;

   AST_ENC_KEEP: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_bit == KEEP) |=> $stable(out_bit));            // R2
   AST_ENC_FLIP: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_bit != KEEP) |=> (out_bit != $past(out_bit))); // R2
   AST_ENC_VALID: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);                                       // R3
   AST_ENC_IDLE: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!out_valid && $stable(out_bit)));               // R6
endmodule

// File: rtl/dpsk_decoder.sv
module dpsk_decoder
   import dpsk_pkg::*;
#(
   parameter rule_e RULE = RULE_XNOR
) (
   input  logic clk,
   input  logic rst,
   input  logic in_valid,
   input  logic in_bit,
   output logic out_valid,
   output logic out_bit
);
   logic last_q;
   logic armed_q;
   logic vld_q;
   logic bit_q;
   logic bit_d;

   dpsk_rule #(.RULE(RULE)) u_rule (
      .a (in_bit),
      .b (last_q),
      .y (bit_d)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         last_q  <= 1'b0;
         armed_q <= 1'b0;
         vld_q   <= 1'b0;
         bit_q   <= 1'b0;
      end else begin
         vld_q <= in_valid && armed_q;
         if (in_valid) begin
            last_q  <= in_bit;
            armed_q <= 1'b1;
            if (armed_q) bit_q <= bit_d;
         end
      end
   end

   assign out_valid = vld_q;
   assign out_bit   = bit_q;

   AST_DEC_FIRST: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !armed_q) |=> !out_valid);   // R4
   AST_DEC_VALID: assert property (@(posedge clk) disable iff (rst)
      (in_valid && armed_q) |=> out_valid);     // R5
   AST_DEC_IDLE: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);                // R5
   AST_DEC_ARMED: assert property (@(posedge clk) disable iff (rst)
      armed_q |=> armed_q);                     // R6
endmodule

// File: rtl/dpsk_codec.sv
module dpsk_codec
   import dpsk_pkg::*;
#(
   parameter rule_e RULE = RULE_XNOR
) (
   input  logic clk,
   input  logic rst,
   input  logic ref_bit,
   input  logic enc_in_valid,
   input  logic enc_in_bit,
   output logic enc_out_valid,
   output logic enc_out_bit,
   input  logic dec_in_valid,
   input  logic dec_in_bit,
   output logic dec_out_valid,
   output logic dec_out_bit
);
   dpsk_encoder #(.RULE(RULE)) u_enc (
      .clk       (clk),
      .rst       (rst),
      .ref_bit   (ref_bit),
      .in_valid  (enc_in_valid),
      .in_bit    (enc_in_bit),
      .out_valid (enc_out_valid),
      .out_bit   (enc_out_bit)
   );

   dpsk_decoder #(.RULE(RULE)) u_dec (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (dec_in_valid),
      .in_bit    (dec_in_bit),
      .out_valid (dec_out_valid),
      .out_bit   (dec_out_bit)
   );
endmodule

// File: tb/dpsk_codec_test.sv
module dpsk_codec_test;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst = 1'b1;
   logic ref_bit = 1'b0;
   logic enc_in_valid = 1'b0, enc_in_bit = 1'b0;
   logic dec_in_valid = 1'b0, dec_in_bit = 1'b0;
   logic enc_out_valid, enc_out_bit, dec_out_valid, dec_out_bit;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   dpsk_codec uut (
      .clk(clk), .rst(rst), .ref_bit(ref_bit),
      .enc_in_valid(enc_in_valid), .enc_in_bit(enc_in_bit),
      .enc_out_valid(enc_out_valid), .enc_out_bit(enc_out_bit),
      .dec_in_valid(dec_in_valid), .dec_in_bit(dec_in_bit),
      .dec_out_valid(dec_out_valid), .dec_out_bit(dec_out_bit)
   );

   task automatic check(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset(input logic r);
      rst = 1'b1; ref_bit = r;
      enc_in_valid = 1'b0; enc_in_bit = 1'b0;
      dec_in_valid = 1'b0; dec_in_bit = 1'b0;
      tick();
      rst = 1'b0;
   endtask

   task automatic t_reset;
      do_reset(1'b1);
      check("R1", "enc valid after reset", enc_out_valid, 1'b1);
      check("R1", "enc ref level 1", enc_out_bit, 1'b1);
      check("R1", "dec valid after reset", dec_out_valid, 1'b0);
      tick();
      check("R3", "enc valid idle", enc_out_valid, 1'b0);
      check("R3", "enc bit held idle", enc_out_bit, 1'b1);
      do_reset(1'b0);
      check("R1", "enc ref level 0", enc_out_bit, 1'b0);
   endtask

   task automatic t_encode(input logic r, input logic [15:0] pat);
      logic prev;
      logic exp;
      do_reset(r);
      prev = r;
      for (int i = 0; i < 16; i++) begin
         enc_in_valid = 1'b1; enc_in_bit = pat[i];
         tick();
         exp = ~(pat[i] ^ prev);
         check("R2", "encoded bit", enc_out_bit, exp);
         check("R3", "enc valid", enc_out_valid, 1'b1);
         prev = exp;
         if (i % 4 == 3) begin
            enc_in_valid = 1'b0; enc_in_bit = ~enc_in_bit;
            tick();
            check("R3", "enc valid in gap", enc_out_valid, 1'b0);
            check("R6", "enc level in gap", enc_out_bit, prev);
         end
      end
      enc_in_valid = 1'b0;
   endtask

   task automatic t_decode(input logic [15:0] rx);
      logic prev;
      do_reset(1'b1);
      prev = 1'b0;
      for (int i = 0; i < 16; i++) begin
         dec_in_valid = 1'b1; dec_in_bit = rx[i];
         tick();
         if (i == 0) begin
            check("R4", "first rx suppressed", dec_out_valid, 1'b0);
         end else begin
            check("R5", "dec valid", dec_out_valid, 1'b1);
            check("R5", "decoded bit", dec_out_bit, ~(rx[i] ^ prev));
         end
         prev = rx[i];
         if (i % 5 == 2) begin
            dec_in_valid = 1'b0; dec_in_bit = ~dec_in_bit;
            tick();
            check("R5", "dec valid in gap", dec_out_valid, 1'b0);
         end
      end
      dec_in_valid = 1'b0;
   endtask

   // c = 0: clean loop; c >= 1: invert the symbol fed in step c.
   task automatic t_loop(input logic r, input logic [15:0] msg, input int c);
      logic exp;
      do_reset(r);
      for (int k = 0; k <= 16; k++) begin
         enc_in_valid = (k < 16);
         enc_in_bit   = (k < 16) ? msg[k] : 1'b0;
         dec_in_valid = enc_out_valid;
         dec_in_bit   = enc_out_bit ^ ((c != 0) && (k == c));
         tick();
         if (k == 0) begin
            check("R4", "loop reference suppressed", dec_out_valid, 1'b0);
         end else begin
            exp = msg[k-1];
            if (c != 0 && (k == c || k == c + 1)) begin
               exp = ~exp;
               check("R8", "paired error", dec_out_bit, exp);
            end else begin
               check("R7", "loop decoded bit", dec_out_bit, exp);
            end
            check("R7", "loop dec valid", dec_out_valid, 1'b1);
         end
      end
      enc_in_valid = 1'b0; dec_in_valid = 1'b0;
   endtask

   task automatic t_ref_ignored;
      logic prev;
      logic exp;
      logic [7:0] msg = 8'b0110_1001;
      do_reset(1'b1);
      prev = 1'b1;
      for (int i = 0; i < 8; i++) begin
         ref_bit = ~ref_bit;
         enc_in_valid = 1'b1; enc_in_bit = msg[i];
         tick();
         exp = ~(msg[i] ^ prev);
         check("R9", "encoded bit with ref toggling", enc_out_bit, exp);
         prev = exp;
      end
      enc_in_valid = 1'b0;
      ref_bit = ~ref_bit;
      tick();
      check("R9", "idle level with ref toggling", enc_out_bit, prev);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_encode(1'b0, 16'b1011_0010_0111_1000);
      t_encode(1'b1, 16'hFFFF);
      t_encode(1'b1, 16'h0000);
      t_decode(16'b0110_1110_0010_1011);
      t_loop(1'b0, 16'b1100_1010_0111_0001, 0);
      t_loop(1'b1, 16'b1001_0110_1101_0011, 0);
      t_loop(1'b1, 16'b1100_1010_0111_0001, 5);
      t_loop(1'b0, 16'b0101_0101_1111_0000, 1);
      t_ref_ignored();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule